// File: doc/BRIEF.md
# Fixed-Point Exception Status Register

This block keeps the integer exception flags of a simple in-order pipeline: a sticky summary-overflow flag, overflow and carry flags for the full width, their 32-bit counterparts, and a small byte-count field that software may write. The flags change in two ways. An ALU result port updates the carry pair and the overflow pair, each under its own enable. A move-to port writes the whole register from a 64-bit word.

A move-from read returns the register as a 64-bit word in which every bit outside the defined fields is zero. The block also builds 4-bit condition fields. One comes from a compare of two operands, either signed or unsigned. The other comes from a record-form result. Both fields carry the current summary-overflow bit.

For divide results, the block decides overflow itself from the quotient magnitude and its sign. A negated zero quotient therefore never reports overflow. Every update is registered at the end of the cycle in which it arrives, so the next instruction already sees the new flags without a stall.

Top module: `fx_status_reg`

## Requirements
- R1: After reset is asserted, `rd_data_o`, `flags_o` and the byte-count field are all zero.
- R2: A move-to write (`mt_valid_i`) loads the fields from `mt_data_i` at LSB-0 bit positions SO=31, OV=30, CA=29, OV32=19, CA32=18 and byte count = 6:0. `rd_data_o` shows those fields at the same positions, and every other bit reads as zero (the upper 32 bits and 28:20 included).
- R3: An ALU update (`alu_valid_i`) with `alu_ca_en_i` high writes CA and CA32. With `alu_ov_en_i` high it writes OV and OV32. A flag pair whose enable is low keeps its value.
- R4: SO is sticky. An ALU update that writes OV=1 also sets SO. Only a move-to write can clear SO.
- R5: When a move-to write and an ALU update arrive in the same cycle, the move-to value is taken and the ALU update is dropped.
- R6: An update is visible on `flags_o`, `rd_data_o` and in the SO bit of both condition fields from the first cycle after it is presented. `flags_o` = {SO, OV, OV32, CA, CA32}, MSB first.
- R7: `cmp_cr_o` = {LT, GT, EQ, SO}, MSB first. It compares `cmp_a_i` with `cmp_b_i` as signed when `cmp_signed_i`=1 and as unsigned otherwise. Exactly one of LT, GT and EQ is set.
- R8: `rec_cr_o` = {NEG, POS, ZERO, SO}, MSB first. It classifies `rec_result_i` as a signed value.
- R9: When `alu_div_i`=1, OV and OV32 come from `div_neg_i` and `div_mag_i` instead of `alu_ov_i`/`alu_ov32_i`. For a negative result, OV = magnitude > 2^63 and OV32 = magnitude > 2^31. For a non-negative result, OV = magnitude >= 2^63 and OV32 = magnitude >= 2^31. A zero magnitude never signals overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alu_valid_i | input | 1 | ALU flag update present |
| alu_ca_en_i | input | 1 | Update the carry pair |
| alu_ca_i | input | 1 | New CA |
| alu_ca32_i | input | 1 | New CA32 |
| alu_ov_en_i | input | 1 | Update the overflow pair |
| alu_ov_i | input | 1 | New OV (non-divide) |
| alu_ov32_i | input | 1 | New OV32 (non-divide) |
| alu_div_i | input | 1 | Take overflow from the divide qualifier |
| div_neg_i | input | 1 | Quotient is to be negated |
| div_mag_i | input | 64 | Unsigned quotient magnitude |
| mt_valid_i | input | 1 | Move-to write |
| mt_data_i | input | 64 | Move-to data |
| cmp_a_i | input | 64 | Compare operand A |
| cmp_b_i | input | 64 | Compare operand B |
| cmp_signed_i | input | 1 | Signed compare |
| rec_result_i | input | 64 | Record-form result |
| rd_data_o | output | 64 | Move-from read data |
| flags_o | output | 5 | {SO, OV, OV32, CA, CA32} |
| cmp_cr_o | output | 4 | Compare condition field |
| rec_cr_o | output | 4 | Record-form condition field |

## Verification
A wrong flag state appears at the ports one cycle after the update that caused it. It shows on `flags_o` and `rd_data_o` and, for SO, in the low bit of both condition fields. A lost sticky SO or a stray reserved bit therefore shows up on the next comparison. A wrong priority between the move-to write and the ALU update, or a wrong divide overflow decision, shows up in the cycle right after the collision or the divide. This is why the reference model is compared on every clock, and the stimulus contains collisions, negated zero quotients and magnitudes at the 2^31 and 2^63 boundaries.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int unsigned POS_SO   = 31;
  localparam int unsigned POS_OV   = 30;
  localparam int unsigned POS_CA   = 29;
  localparam int unsigned POS_OV32 = 19;
  localparam int unsigned POS_CA32 = 18;
  localparam int unsigned CNT_W    = 7;

  typedef struct packed {
    logic so;
    logic ov;
    logic ov32;
    logic ca;
    logic ca32;
  } fx_flags_t;

  function automatic logic [63:0] fx_mask();
    logic [63:0] m;
    m = '0;
    m[POS_SO]   = 1'b1;
    m[POS_OV]   = 1'b1;
    m[POS_CA]   = 1'b1;
    m[POS_OV32] = 1'b1;
    m[POS_CA32] = 1'b1;
    m[CNT_W-1:0] = '1;
    return m;
  endfunction
endpackage

// File: rtl/fx_div_ovf.sv
module fx_div_ovf #(
  parameter int unsigned XLEN = 64
) (
  input  logic            neg_i,
  input  logic [XLEN-1:0] mag_i,
  output logic            ov_o,
  output logic            ov32_o
);
  localparam int unsigned HALF = XLEN / 2;
  localparam logic [XLEN-1:0] LIM_W = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] LIM_H = {{(XLEN-HALF){1'b0}}, 1'b1, {(HALF-1){1'b0}}};

  // a negative result may reach exactly -2^(n-1); zero never overflows
  always_comb begin
    if (neg_i) begin
      ov_o   = mag_i > LIM_W;
      ov32_o = mag_i > LIM_H;
    end else begin
      ov_o   = mag_i >= LIM_W;
      ov32_o = mag_i >= LIM_H;
    end
  end
endmodule

// File: rtl/fx_flag_state.sv
module fx_flag_state
  import fx_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alu_valid_i,
  input  logic             ca_en_i,
  input  logic             ca_i,
  input  logic             ca32_i,
  input  logic             ov_en_i,
  input  logic             ov_i,
  input  logic             ov32_i,
  input  logic             mt_valid_i,
  input  logic [XLEN-1:0]  mt_data_i,
  output fx_flags_t        flags_o,
  output logic [CNT_W-1:0] cnt_o
);
  fx_flags_t        flags_q, flags_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    flags_d = flags_q;
    cnt_d   = cnt_q;
    if (mt_valid_i) begin
      flags_d.so   = mt_data_i[POS_SO];
      flags_d.ov   = mt_data_i[POS_OV];
      flags_d.ca   = mt_data_i[POS_CA];
      flags_d.ov32 = mt_data_i[POS_OV32];
      flags_d.ca32 = mt_data_i[POS_CA32];
      cnt_d        = mt_data_i[CNT_W-1:0];
    end else if (alu_valid_i) begin
      if (ca_en_i) begin
        flags_d.ca   = ca_i;
        flags_d.ca32 = ca32_i;
      end
      if (ov_en_i) begin
        flags_d.ov   = ov_i;
        flags_d.ov32 = ov32_i;
        flags_d.so   = flags_q.so | ov_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      cnt_q   <= '0;
    end else begin
      flags_q <= flags_d;
      cnt_q   <= cnt_d;
    end
  end

  assign flags_o = flags_q;
  assign cnt_o   = cnt_q;

  assert_so_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q.so && !mt_valid_i) |=> flags_q.so);

  assert_ov_sets_so_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mt_valid_i && alu_valid_i && ov_en_i && ov_i) |=> flags_q.so);

  assert_carry_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mt_valid_i && !(alu_valid_i && ca_en_i)) |=> $stable({flags_q.ca, flags_q.ca32}));

  assert_ovf_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mt_valid_i && !(alu_valid_i && ov_en_i)) |=> $stable({flags_q.ov, flags_q.ov32}));
endmodule

// File: rtl/fx_cr_gen.sv
module fx_cr_gen #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] cmp_a_i,
  input  logic [XLEN-1:0] cmp_b_i,
  input  logic            cmp_signed_i,
  input  logic [XLEN-1:0] rec_result_i,
  input  logic            so_i,
  output logic [3:0]      cmp_cr_o,
  output logic [3:0]      rec_cr_o
);
  logic lt, gt, eq;
  logic r_neg, r_zero;

  always_comb begin
    eq = (cmp_a_i == cmp_b_i);
    if (cmp_signed_i) lt = $signed(cmp_a_i) < $signed(cmp_b_i);
    else              lt = cmp_a_i < cmp_b_i;
    gt = !lt && !eq;
  end

  assign r_neg    = rec_result_i[XLEN-1];
  assign r_zero   = (rec_result_i == '0);
  assign cmp_cr_o = {lt, gt, eq, so_i};
  assign rec_cr_o = {r_neg, !r_neg && !r_zero, r_zero, so_i};
endmodule

// File: rtl/fx_status_reg.sv
module fx_status_reg
  import fx_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            alu_valid_i,
  input  logic            alu_ca_en_i,
  input  logic            alu_ca_i,
  input  logic            alu_ca32_i,
  input  logic            alu_ov_en_i,
  input  logic            alu_ov_i,
  input  logic            alu_ov32_i,
  input  logic            alu_div_i,
  input  logic            div_neg_i,
  input  logic [XLEN-1:0] div_mag_i,
  input  logic            mt_valid_i,
  input  logic [XLEN-1:0] mt_data_i,
  input  logic [XLEN-1:0] cmp_a_i,
  input  logic [XLEN-1:0] cmp_b_i,
  input  logic            cmp_signed_i,
  input  logic [XLEN-1:0] rec_result_i,
  output logic [XLEN-1:0] rd_data_o,
  output logic [4:0]      flags_o,
  output logic [3:0]      cmp_cr_o,
  output logic [3:0]      rec_cr_o
);
  localparam logic [XLEN-1:0] RD_MASK = XLEN'(fx_mask());

  fx_flags_t        flags;
  logic [CNT_W-1:0] cnt;
  logic             div_ov, div_ov32;
  logic             ov_sel, ov32_sel;

  fx_div_ovf #(.XLEN(XLEN)) u_div_ovf (
    .neg_i  (div_neg_i),
    .mag_i  (div_mag_i),
    .ov_o   (div_ov),
    .ov32_o (div_ov32)
  );

  assign ov_sel   = alu_div_i ? div_ov   : alu_ov_i;
  assign ov32_sel = alu_div_i ? div_ov32 : alu_ov32_i;

  fx_flag_state #(.XLEN(XLEN)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alu_valid_i (alu_valid_i),
    .ca_en_i     (alu_ca_en_i),
    .ca_i        (alu_ca_i),
    .ca32_i      (alu_ca32_i),
    .ov_en_i     (alu_ov_en_i),
    .ov_i        (ov_sel),
    .ov32_i      (ov32_sel),
    .mt_valid_i  (mt_valid_i),
    .mt_data_i   (mt_data_i),
    .flags_o     (flags),
    .cnt_o       (cnt)
  );

  fx_cr_gen #(.XLEN(XLEN)) u_cr (
    .cmp_a_i      (cmp_a_i),
    .cmp_b_i      (cmp_b_i),
    .cmp_signed_i (cmp_signed_i),
    .rec_result_i (rec_result_i),
    .so_i         (flags.so),
    .cmp_cr_o     (cmp_cr_o),
    .rec_cr_o     (rec_cr_o)
  );

  always_comb begin
    rd_data_o            = '0;
    rd_data_o[POS_SO]    = flags.so;
    rd_data_o[POS_OV]    = flags.ov;
    rd_data_o[POS_CA]    = flags.ca;
    rd_data_o[POS_OV32]  = flags.ov32;
    rd_data_o[POS_CA32]  = flags.ca32;
    rd_data_o[CNT_W-1:0] = cnt;
  end

  assign flags_o = flags;

  assert_mt_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mt_valid_i |=> (rd_data_o == ($past(mt_data_i) & RD_MASK)));

  assert_cmp_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(cmp_cr_o[3:1]));

  assert_div_zero_no_ovf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mt_valid_i && alu_valid_i && alu_ov_en_i && alu_div_i && div_mag_i == '0)
      |=> (!flags_o[3] && !flags_o[2]));

  assert_cr_so_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_cr_o[0] == flags_o[4]) && (rec_cr_o[0] == flags_o[4]));
endmodule

// File: tb/tb_fx_status_reg.sv
`timescale 1ns/1ps
module tb_fx_status_reg;
  logic        clk = 0, rst_n = 0;
  logic        alu_valid = 0, ca_en = 0, ca = 0, ca32 = 0, ov_en = 0, ov = 0, ov32 = 0;
  logic        alu_div = 0, div_neg = 0;
  logic [63:0] div_mag = 0;
  logic        mt_valid = 0;
  logic [63:0] mt_data = 0, cmp_a = 0, cmp_b = 0, rec_res = 0;
  logic        cmp_sgn = 0;
  logic [63:0] rd_data;
  logic [4:0]  flags;
  logic [3:0]  cmp_cr, rec_cr;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state
  bit m_so, m_ov, m_ov32, m_ca, m_ca32;
  bit [6:0] m_cnt;

  always #2.5 clk = ~clk;

  fx_status_reg dut (
    .clk_i(clk), .rst_ni(rst_n),
    .alu_valid_i(alu_valid), .alu_ca_en_i(ca_en), .alu_ca_i(ca), .alu_ca32_i(ca32),
    .alu_ov_en_i(ov_en), .alu_ov_i(ov), .alu_ov32_i(ov32),
    .alu_div_i(alu_div), .div_neg_i(div_neg), .div_mag_i(div_mag),
    .mt_valid_i(mt_valid), .mt_data_i(mt_data),
    .cmp_a_i(cmp_a), .cmp_b_i(cmp_b), .cmp_signed_i(cmp_sgn), .rec_result_i(rec_res),
    .rd_data_o(rd_data), .flags_o(flags), .cmp_cr_o(cmp_cr), .rec_cr_o(rec_cr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] exp_rd();
    logic [63:0] r = '0;
    r[31] = m_so; r[30] = m_ov; r[29] = m_ca; r[19] = m_ov32; r[18] = m_ca32;
    r[6:0] = m_cnt;
    return r;
  endfunction

  // compare at negedge, then advance model with the inputs the next posedge samples
  always @(negedge clk) begin
    if (!done) begin
      bit lt, eq, gt, dov, dov32;
      if (!rst_n) begin
        m_so = 0; m_ov = 0; m_ov32 = 0; m_ca = 0; m_ca32 = 0; m_cnt = 0;
        chk("R1 reset read", rd_data, 64'd0);
        chk("R1 reset flags", {59'd0, flags}, 64'd0);
      end else begin
        chk("R2 read data", rd_data, exp_rd());
        chk("R3/R4/R6 flags", {59'd0, flags}, {59'd0, m_so, m_ov, m_ov32, m_ca, m_ca32});
        eq = (cmp_a == cmp_b);
        lt = cmp_sgn ? ($signed(cmp_a) < $signed(cmp_b)) : (cmp_a < cmp_b);
        gt = !lt && !eq;
        chk("R7 compare field", {60'd0, cmp_cr}, {60'd0, lt, gt, eq, m_so});
        chk("R8 record field", {60'd0, rec_cr},
            {60'd0, rec_res[63], !rec_res[63] && rec_res != 0, rec_res == 0, m_so});
        if (div_mag == 0) begin dov = 0; dov32 = 0; end
        else if (div_neg) begin
          dov = div_mag > 64'h8000_0000_0000_0000; dov32 = div_mag > 64'h8000_0000;
        end else begin
          dov = div_mag >= 64'h8000_0000_0000_0000; dov32 = div_mag >= 64'h8000_0000;
        end
        if (mt_valid) begin // R5: move-to takes priority
          m_so = mt_data[31]; m_ov = mt_data[30]; m_ca = mt_data[29];
          m_ov32 = mt_data[19]; m_ca32 = mt_data[18]; m_cnt = mt_data[6:0];
        end else if (alu_valid) begin
          if (ca_en) begin m_ca = ca; m_ca32 = ca32; end
          if (ov_en) begin
            m_ov = alu_div ? dov : ov;      // R9
            m_ov32 = alu_div ? dov32 : ov32;
            m_so = m_so | m_ov;
          end
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    alu_valid = 0; mt_valid = 0; ca_en = 0; ov_en = 0; alu_div = 0;
  endtask

  initial begin
    #10000000;
    if (!done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    // R2: all-ones write, reserved bits must read zero
    mt_valid = 1; mt_data = '1; step();
    // R4: writing OV=0 must not clear SO
    idle(); alu_valid = 1; ov_en = 1; ov = 0; ov32 = 0; step();
    // R3: carry only, overflow held
    idle(); alu_valid = 1; ca_en = 1; ca = 0; ca32 = 1; step();
    // R5: collision
    idle(); mt_valid = 1; mt_data = 64'h0000_0000_0004_0055;
    alu_valid = 1; ov_en = 1; ov = 1; ca_en = 1; ca = 1; step();
    // R9: negated zero quotient, boundary magnitudes
    idle(); alu_valid = 1; ov_en = 1; alu_div = 1; div_neg = 1; div_mag = 0; step();
    div_neg = 1; div_mag = 64'h8000_0000_0000_0000; step();
    div_neg = 0; div_mag = 64'h8000_0000; step();
    div_neg = 1; div_mag = 64'h8000_0000_0000_0001; step();
    // R6: next-cycle visibility of SO in condition fields
    idle(); cmp_a = 64'hFFFF_FFFF_FFFF_FFFF; cmp_b = 1; cmp_sgn = 1; rec_res = 0; step();
    cmp_sgn = 0; step();
    idle(); mt_valid = 1; mt_data = 0; step();
    for (int i = 0; i < 2000; i++) begin
      idle();
      alu_valid = $urandom_range(1, 0) != 0;
      ca_en = $urandom_range(1, 0) != 0; ca = $urandom_range(1, 0) != 0;
      ca32 = $urandom_range(1, 0) != 0;
      ov_en = $urandom_range(1, 0) != 0; ov = ($urandom_range(7, 0) == 0);
      ov32 = $urandom_range(1, 0) != 0;
      alu_div = $urandom_range(2, 0) == 0; div_neg = $urandom_range(1, 0) != 0;
      case ($urandom_range(5, 0))
        0: div_mag = 0;
        1: div_mag = 64'h8000_0000_0000_0000;
        2: div_mag = 64'h8000_0000;
        3: div_mag = 64'h7FFF_FFFF;
        4: div_mag = 64'h8000_0000_0000_0001;
        default: div_mag = {$urandom, $urandom};
      endcase
      mt_valid = ($urandom_range(7, 0) == 0); mt_data = {$urandom, $urandom};
      cmp_a = {$urandom, $urandom};
      cmp_b = ($urandom_range(3, 0) == 0) ? cmp_a : {$urandom, $urandom};
      cmp_sgn = $urandom_range(1, 0) != 0;
      rec_res = ($urandom_range(3, 0) == 0) ? 64'd0 : {$urandom, $urandom};
      step();
    end
    idle(); step(); step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule